// File: doc/BRIEF.md
# Pixel Matrix Periphery Readout Sequencer

This block sits in the periphery of a pixel sensor. Each column of the matrix offers at most one latched hit at a time: a valid flag, a row index and the timestamp the pixel stored when it crossed threshold. A free-running timestamp counter is also fed in. The sequencer repeats a two-phase cycle. In the load phase it copies one hit from every column that has one onto a shared periphery bus, all at the same instant. It clears those pixels in that same cycle so that they can take new hits. In the drain phase it sends the bus contents one word per cycle.

The output is a word stream for a downstream encoder and serializer, together with a flag that separates data words from control words. No hit data leaves the block while columns are loading. A counter word and then a sync word go out in those cycles, so the receiver can keep its alignment. When nothing is pending, a fixed idle word goes out on every cycle. Only real hits become data words. Once the bus is empty, the sequencer loads again straight away if any column still holds a hit. Otherwise it returns to idle. The reference clock is nominally 62.5 MHz.

Top module: `pixRdoSeq`

## Requirements
- R1: During and right after reset, the output is the idle word, the data flag is low, the load strobe is low and no column clear is asserted.
- R2: While no hit is pending, every cycle emits the idle control word: data flag 0, kind field (top two bits) 2'b00, low TS_W bits 8'hBC, all other bits 0. No load strobe is asserted.
- R3: One cycle after a column hit is seen while idle, a load cycle follows. In it the load strobe is high and the output is a counter word: data flag 0, kind 2'b01, low TS_W bits equal to the timestamp counter input in that same cycle.
- R4: The cycle after every load cycle emits a sync word: data flag 0, kind 2'b10, low TS_W bits 8'h3C. It never carries hit data and is never another load cycle.
- R5: After the sync word, each captured hit is sent once as a data word, one per cycle, in ascending column order. The data flag is 1 and the word is {column index, row, timestamp}, with the column in the top bits and the timestamp in the low TS_W bits. A column that had no hit at load time produces no word.
- R6: A column clear is asserted only in a load cycle, and exactly for the columns whose valid flag is high in that cycle.
- R7: In the cycle after the last data word of a drain, a new load cycle follows if any column valid flag was high in that last-word cycle. This includes hits that arrived during the drain. If none was high, the idle word follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colHitValid | input | NUM_COLS | Per-column flag: a latched hit is waiting |
| colHitRow | input | NUM_COLS*ROW_W | Row index of each column's waiting hit, column 0 in the low bits |
| colHitTs | input | NUM_COLS*TS_W | Stored timestamp of each column's waiting hit, column 0 in the low bits |
| tsCount | input | TS_W | Free-running timestamp counter |
| colLoad | output | 1 | Column-to-periphery load strobe |
| colClear | output | NUM_COLS | Per-column pixel clear that re-arms the hit just taken |
| outWord | output | COL_W+ROW_W+TS_W | Output word for the serializer |
| outIsData | output | 1 | 1 for a hit data word, 0 for a control/counter word |

## Verification
The delicate coincidence is the last data word of a drain landing in the same cycle that a column presents a fresh hit. The bus-empty decision and the reload decision then meet on one clock edge. The bench provokes it by holding a single hit in column 0. It injects a hit into column 2 exactly in the cycle where column 0's data word is on the output. The scoreboard then expects a counter word with a clear of column 2 alone on the very next cycle, with no idle word in between. It also expects the pixel cleared at the first load not to be cleared again.

// File: rtl/pixRdoPkg.sv
package pixRdoPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SYNC  = 2'd2,
    ST_DRAIN = 2'd3
  } seqState_e;

  typedef enum logic [1:0] {
    OS_IDLE = 2'd0,
    OS_CNT  = 2'd1,
    OS_SYNC = 2'd2,
    OS_DATA = 2'd3
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadStb;
    logic    drainStb;
    outSel_e outSel;
  } seqCtrl_t;

  // kind field of control words (top two bits of the output word)
  localparam logic [1:0] KIND_IDLE = 2'b00;
  localparam logic [1:0] KIND_CNT  = 2'b01;
  localparam logic [1:0] KIND_SYNC = 2'b10;

  // payload codes of the fixed control words
  localparam logic [7:0] IDLE_CODE = 8'hBC;
  localparam logic [7:0] SYNC_CODE = 8'h3C;

endpackage

// File: rtl/pixRdoCtrl.sv
module pixRdoCtrl
  import pixRdoPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyHit,
  input  logic     busAny,
  input  logic     busLast,
  output seqCtrl_t ctrl
);

  seqState_e state;
  seqState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    ctrl.loadStb  = 1'b0;
    ctrl.drainStb = 1'b0;
    ctrl.outSel   = OS_IDLE;
    case (state)
      ST_IDLE: begin
        if (anyHit) stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        ctrl.loadStb = 1'b1;
        ctrl.outSel  = OS_CNT;
        stateNext    = ST_SYNC;
      end
      ST_SYNC: begin
        ctrl.outSel = OS_SYNC;
        if (busAny)      stateNext = ST_DRAIN;
        else if (anyHit) stateNext = ST_LOAD;
        else             stateNext = ST_IDLE;
      end
      ST_DRAIN: begin
        ctrl.drainStb = 1'b1;
        ctrl.outSel   = OS_DATA;
        if (busLast) stateNext = anyHit ? ST_LOAD : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pixRdoPath.sv
module pixRdoPath
  import pixRdoPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int ROW_W    = 4,
  parameter int TS_W     = 8,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int WORD_W  = COL_W + ROW_W + TS_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqCtrl_t                  ctrl,
  input  logic [NUM_COLS-1:0]       colHitValid,
  input  logic [NUM_COLS*ROW_W-1:0] colHitRow,
  input  logic [NUM_COLS*TS_W-1:0]  colHitTs,
  input  logic [TS_W-1:0]           tsCount,
  output logic                      busAny,
  output logic                      busLast,
  output logic                      colLoad,
  output logic [NUM_COLS-1:0]       colClear,
  output logic [WORD_W-1:0]         outWord,
  output logic                      outIsData
);

  logic [NUM_COLS-1:0] busValid;
  logic [NUM_COLS-1:0] selOh;
  logic [ROW_W-1:0]    busRow [NUM_COLS];
  logic [TS_W-1:0]     busTs  [NUM_COLS];
  logic [COL_W-1:0]    selIdx;

  // lowest occupied bus slot goes first
  assign selOh = busValid & (~busValid + NUM_COLS'(1));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COLS; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          busValid[gi] <= 1'b0;
          busRow[gi]   <= '0;
          busTs[gi]    <= '0;
        end else if (ctrl.loadStb) begin
          busValid[gi] <= colHitValid[gi];
          if (colHitValid[gi]) begin
            busRow[gi] <= colHitRow[gi*ROW_W +: ROW_W];
            busTs[gi]  <= colHitTs[gi*TS_W +: TS_W];
          end
        end else if (ctrl.drainStb && selOh[gi]) begin
          busValid[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    selIdx = '0;
    for (int i = NUM_COLS - 1; i >= 0; i--) begin
      if (busValid[i]) selIdx = COL_W'(i);
    end
  end

  assign busAny   = |busValid;
  assign busLast  = busAny && ((busValid & (busValid - NUM_COLS'(1))) == '0);
  assign colLoad  = ctrl.loadStb;
  assign colClear = ctrl.loadStb ? colHitValid : '0;

  always_comb begin
    outWord   = '0;
    outIsData = 1'b0;
    case (ctrl.outSel)
      OS_CNT: begin
        outWord[WORD_W-1 -: 2] = KIND_CNT;
        outWord[TS_W-1:0]      = tsCount;
      end
      OS_SYNC: begin
        outWord[WORD_W-1 -: 2] = KIND_SYNC;
        outWord[TS_W-1:0]      = TS_W'(SYNC_CODE);
      end
      OS_DATA: begin
        outWord   = {selIdx, busRow[selIdx], busTs[selIdx]};
        outIsData = 1'b1;
      end
      default: begin
        outWord[WORD_W-1 -: 2] = KIND_IDLE;
        outWord[TS_W-1:0]      = TS_W'(IDLE_CODE);
      end
    endcase
  end

endmodule

// File: rtl/pixRdoSeq.sv
module pixRdoSeq
  import pixRdoPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int ROW_W    = 4,
  parameter int TS_W     = 8,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int WORD_W  = COL_W + ROW_W + TS_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_COLS-1:0]       colHitValid,
  input  logic [NUM_COLS*ROW_W-1:0] colHitRow,
  input  logic [NUM_COLS*TS_W-1:0]  colHitTs,
  input  logic [TS_W-1:0]           tsCount,
  output logic                      colLoad,
  output logic [NUM_COLS-1:0]       colClear,
  output logic [WORD_W-1:0]         outWord,
  output logic                      outIsData
);

  seqCtrl_t ctrl;
  logic     busAny;
  logic     busLast;

  pixRdoCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyHit (|colHitValid),
    .busAny (busAny),
    .busLast(busLast),
    .ctrl   (ctrl)
  );

  pixRdoPath #(
    .NUM_COLS(NUM_COLS),
    .ROW_W   (ROW_W),
    .TS_W    (TS_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .colHitValid(colHitValid),
    .colHitRow  (colHitRow),
    .colHitTs   (colHitTs),
    .tsCount    (tsCount),
    .busAny     (busAny),
    .busLast    (busLast),
    .colLoad    (colLoad),
    .colClear   (colClear),
    .outWord    (outWord),
    .outIsData  (outIsData)
  );

endmodule

// File: rtl/pixRdoSeqChk.sv
module pixRdoSeqChk
  import pixRdoPkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int ROW_W    = 4,
  parameter int TS_W     = 8,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int WORD_W  = COL_W + ROW_W + TS_W
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_COLS-1:0]       colHitValid,
  input logic [NUM_COLS*ROW_W-1:0] colHitRow,
  input logic [NUM_COLS*TS_W-1:0]  colHitTs,
  input logic [TS_W-1:0]           tsCount,
  input logic                      colLoad,
  input logic [NUM_COLS-1:0]       colClear,
  input logic [WORD_W-1:0]         outWord,
  input logic                      outIsData
);

  logic [1:0]       kind;
  logic [COL_W-1:0] colField;
  assign kind     = outWord[WORD_W-1 -: 2];
  assign colField = outWord[WORD_W-1 -: COL_W];

  // R6
  clear_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colClear != '0) |-> colLoad);

  // R6
  clear_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |-> ((colClear & ~colHitValid) == '0));

  // R3
  load_counter_chk: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |-> (!outIsData && kind == KIND_CNT && outWord[TS_W-1:0] == tsCount));

  // R4
  sync_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |=> (!colLoad && !outIsData && kind == KIND_SYNC));

  // R5
  ascending_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outIsData && $past(outIsData)) |-> (colField > $past(colField)));

  // R2
  idle_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outIsData && kind == KIND_IDLE) |-> (!colLoad && outWord[TS_W-1:0] == TS_W'(IDLE_CODE)));

  logic unusedIn;
  assign unusedIn = ^{colHitRow, colHitTs};

endmodule

bind pixRdoSeq pixRdoSeqChk #(
  .NUM_COLS(NUM_COLS),
  .ROW_W   (ROW_W),
  .TS_W    (TS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .colHitValid(colHitValid),
  .colHitRow  (colHitRow),
  .colHitTs   (colHitTs),
  .tsCount    (tsCount),
  .colLoad    (colLoad),
  .colClear   (colClear),
  .outWord    (outWord),
  .outIsData  (outIsData)
);

// File: tb/pixRdoSeq_bench.sv
`timescale 1ns/1ps
module pixRdoSeq_bench;

  localparam int NUM_COLS = 4;
  localparam int ROW_W    = 4;
  localparam int TS_W     = 8;
  localparam int COL_W    = 2;
  localparam int WORD_W   = COL_W + ROW_W + TS_W;
  localparam int QD       = 8;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic [NUM_COLS-1:0]       hv = '0;
  logic [NUM_COLS*ROW_W-1:0] hr = '0;
  logic [NUM_COLS*TS_W-1:0]  hts = '0;
  logic [TS_W-1:0]           tsCount = '0;
  logic                      colLoad;
  logic [NUM_COLS-1:0]       colClear;
  logic [WORD_W-1:0]         outWord;
  logic                      outIsData;

  int checks = 0;
  int failures = 0;
  bit monOn = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tsCount <= tsCount + 1'b1;

  pixRdoSeq #(.NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .TS_W(TS_W)) u_pixRdoSeq (
    .clk(clk), .rstN(rstN), .colHitValid(hv), .colHitRow(hr), .colHitTs(hts),
    .tsCount(tsCount), .colLoad(colLoad), .colClear(colClear),
    .outWord(outWord), .outIsData(outIsData)
  );

  // column model: each column holds a queue of pending hits, front one presented
  logic [ROW_W-1:0] qRow [NUM_COLS][QD];
  logic [TS_W-1:0]  qTs  [NUM_COLS][QD];
  int qHead [NUM_COLS];
  int qTail [NUM_COLS];

  initial for (int c = 0; c < NUM_COLS; c++) begin qHead[c] = 0; qTail[c] = 0; end

  task automatic packCols(output logic [NUM_COLS-1:0] v, output logic [NUM_COLS*ROW_W-1:0] r,
                          output logic [NUM_COLS*TS_W-1:0] t);
    v = '0; r = '0; t = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (qHead[c] != qTail[c]) begin
        v[c] = 1'b1;
        r[c*ROW_W +: ROW_W] = qRow[c][qHead[c] % QD];
        t[c*TS_W +: TS_W]   = qTs[c][qHead[c] % QD];
      end
    end
  endtask

  always @(posedge clk) begin
    logic [NUM_COLS-1:0]       v;
    logic [NUM_COLS*ROW_W-1:0] r;
    logic [NUM_COLS*TS_W-1:0]  t;
    for (int c = 0; c < NUM_COLS; c++)
      if (rstN && colClear[c]) qHead[c] = qHead[c] + 1;
    packCols(v, r, t);
    hv <= v; hr <= r; hts <= t;
  end

  task automatic refreshNow();
    logic [NUM_COLS-1:0]       v;
    logic [NUM_COLS*ROW_W-1:0] r;
    logic [NUM_COLS*TS_W-1:0]  t;
    packCols(v, r, t);
    hv = v; hr = r; hts = t;
  endtask

  // scoreboard
  typedef struct {
    logic [WORD_W-1:0]   word;
    bit                  isData;
    bit                  isCnt;
    bit                  load;
    logic [NUM_COLS-1:0] clr;
    string               req;
  } expItem_t;
  expItem_t expQ[$];

  function automatic logic [WORD_W-1:0] ctlWord(logic [1:0] kind, logic [TS_W-1:0] pl);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1 -: 2] = kind;
    w[TS_W-1:0] = pl;
    return w;
  endfunction

  function automatic expItem_t mkItem(logic [WORD_W-1:0] w, bit d, bit cnt, bit ld,
                                      logic [NUM_COLS-1:0] clr, string req);
    expItem_t e;
    e.word = w; e.isData = d; e.isCnt = cnt; e.load = ld; e.clr = clr; e.req = req;
    return e;
  endfunction

  task automatic addHit(int c, logic [ROW_W-1:0] row, logic [TS_W-1:0] ts);
    qRow[c][qTail[c] % QD] = row;
    qTs[c][qTail[c] % QD]  = ts;
    qTail[c] = qTail[c] + 1;
  endtask

  // push the expected rounds for everything pending; the caller is in an idle cycle
  task automatic commitBurst();
    int h [NUM_COLS];
    bit first = 1'b1;
    expQ.push_back(mkItem(ctlWord(2'b00, 8'hBC), 0, 0, 0, '0, "R2"));
    for (int c = 0; c < NUM_COLS; c++) h[c] = qHead[c];
    forever begin
      logic [NUM_COLS-1:0] m = '0;
      for (int c = 0; c < NUM_COLS; c++) if (h[c] != qTail[c]) m[c] = 1'b1;
      if (m == '0) break;
      // first load follows idle (R3); later ones follow a drain (R7)
      expQ.push_back(mkItem('0, 0, 1, 1, m, first ? "R3" : "R7"));
      expQ.push_back(mkItem(ctlWord(2'b10, 8'h3C), 0, 0, 0, '0, "R4"));
      for (int c = 0; c < NUM_COLS; c++) begin
        if (m[c]) begin
          expQ.push_back(mkItem({COL_W'(c), qRow[c][h[c] % QD], qTs[c][h[c] % QD]},
                                1, 0, 0, '0, "R5"));
          h[c] = h[c] + 1;
        end
      end
      first = 1'b0;
    end
    refreshNow();
  endtask

  task automatic waitQuiet();
    while (expQ.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (monOn && rstN) begin
      expItem_t e;
      logic [WORD_W-1:0] ew;
      if (expQ.size() == 0) e = mkItem(ctlWord(2'b00, 8'hBC), 0, 0, 0, '0, "R2");
      else e = expQ.pop_front();
      ew = e.isCnt ? ctlWord(2'b01, tsCount) : e.word;
      checks++;
      if (outWord !== ew || outIsData !== e.isData) begin
        failures++;
        $display("FAIL %s word: got %h/%0b expected %h/%0b", e.req, outWord, outIsData, ew, e.isData);
      end
      checks++;
      if (colLoad !== e.load || colClear !== e.clr) begin
        failures++;
        $display("FAIL %s/R6 load/clear: got %0b/%b expected %0b/%b",
                 e.req, colLoad, colClear, e.load, e.clr);
      end
    end
  end

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outWord !== ctlWord(2'b00, 8'hBC) || outIsData !== 1'b0 || colLoad !== 1'b0 || colClear !== '0) begin
      failures++;
      $display("FAIL R1 reset: got %h/%0b/%0b/%b expected %h/0/0/0",
               outWord, outIsData, colLoad, colClear, ctlWord(2'b00, 8'hBC));
    end
    @(posedge clk); #1;
    rstN = 1'b1;
    monOn = 1'b1;

    // R2: quiet stretch, monitor expects idle every cycle
    repeat (10) @(posedge clk);
    #1;

    // R3 R5: single hit in the top column
    addHit(3, 4'h9, 8'h5A);
    commitBurst();
    waitQuiet();

    // R5: all columns, ascending order
    addHit(0, 4'h1, 8'h11);
    addHit(1, 4'h2, 8'h22);
    addHit(2, 4'h3, 8'h33);
    addHit(3, 4'h4, 8'h44);
    commitBurst();
    waitQuiet();

    // R5 R7: sparse columns plus a column with three hits -> back-to-back reloads
    addHit(0, 4'hA, 8'h01);
    addHit(2, 4'hC, 8'h03);
    addHit(1, 4'h5, 8'h10);
    addHit(1, 4'h6, 8'h11);
    addHit(1, 4'h7, 8'h12);
    commitBurst();
    waitQuiet();

    // R7: hit injected in the cycle of the last data word
    addHit(0, 4'hE, 8'h77);
    commitBurst();
    repeat (3) @(posedge clk);
    #1;
    addHit(2, 4'hD, 8'h88);
    refreshNow();
    expQ.push_back(mkItem('0, 0, 1, 1, 4'b0100, "R7"));
    expQ.push_back(mkItem(ctlWord(2'b10, 8'h3C), 0, 0, 0, '0, "R4"));
    expQ.push_back(mkItem({2'd2, 4'hD, 8'h88}, 1, 0, 0, '0, "R5"));
    waitQuiet();

    // R2: idle again after everything drained
    repeat (8) @(posedge clk);
    #1;
    finishRun();
  end

endmodule